// File: doc/BRIEF.md
# Bus-Mastering Temperature Sensor Sequencer

This block measures on-die temperature sensors without owning a converter. A round timer periodically starts a measurement round. For each enabled sensing point, in ascending index order, the block drives an external ADC and an analog sensor multiplexer by issuing writes on a simple valid/ready bus master port. The written addresses and data words all come from configuration inputs. The block then polls a programmed address until a valid flag of programmed position and polarity appears. It extracts the 12-bit voltage, right-shifted by a programmed amount, and keeps it in that point's result register.

Configuration arrives as static inputs driven by the surrounding register space. Results and a sticky poll-timeout flag are presented as outputs. A point whose poll gives up keeps its earlier result and moves on. All-ones in the timeout input makes polling unbounded.

Top module: `tsense_sequencer`

## Requirements
- R1: While `run` is high, a round starts every `unit_cnt * PRE * round_ivl` clocks, with PRE = 256 by default. The first bus request follows the first period by at most four clocks. While `run` is low, no round starts.
- R2: Points are visited in ascending index order, and only those with their bit set in `pt_en` are visited. A disabled point gets no transactions and its result is unchanged.
- R3: For each visited point the writes come in this order. First a write of `mux_val` to `mux_addr`, only when `wr_ctl[1]` is 1. Then a write of that point's `pnp_val` slice to `pnp_addr`, only when `wr_ctl[0]` is 1. Then always a write of `en_val` to `en_addr`.
- R4: After the enable write, the block reads `vld_addr` repeatedly, with `poll_gap` idle clocks between reads. A read counts as valid when bit `vld_mask[4:0]` of the read data equals `vld_mask[5]`, where 1 means active high.
- R5: With `rd_sep` = 0, the voltage comes from the same word as the valid bit. With `rd_sep` = 1, one extra read of `volt_addr` follows the valid poll and supplies the voltage.
- R6: The stored result is bits 11:0 of the voltage word shifted right by `volt_shift`. Point p occupies `res_flat[12p+11:12p]`.
- R7: When `tmo_polls` invalid polls have been seen (with `tmo_polls` ≥ 1), the point is abandoned. `err_sticky` then sets and stays set until reset, and the point's result is kept. When `tmo_polls` is all ones, polling never gives up.
- R8: A bus request holds `m_valid`, `m_write`, `m_addr` and `m_wdata` stable until `m_ready` is seen. Reads drive `m_wdata` to 0.
- R9: After reset, all results are 0, `err_sticky` is 0 and `m_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the round timer |
| unit_cnt | input | 10 | Base tick length, in units of PRE clocks |
| round_ivl | input | 10 | Round period in base ticks |
| pt_en | input | 4 | Sensing point enable mask |
| wr_ctl | input | 2 | bit0: sensor-select write on, bit1: ADC mux write on |
| mux_addr | input | 32 | ADC mux write address |
| mux_val | input | 32 | ADC mux write data |
| pnp_addr | input | 32 | Sensor-select write address |
| pnp_val | input | 128 | Per-point sensor-select values, point p at [32p+31:32p] |
| en_addr | input | 32 | ADC start write address |
| en_val | input | 32 | ADC start write data |
| vld_addr | input | 32 | Valid poll read address |
| volt_addr | input | 32 | Separate voltage read address |
| rd_sep | input | 1 | 1: voltage read separately |
| vld_mask | input | 6 | [4:0] valid bit position, [5] polarity |
| volt_shift | input | 5 | Right shift of the voltage word |
| poll_gap | input | 8 | Idle clocks between polls |
| tmo_polls | input | 32 | Invalid polls before giving up, all ones = never |
| m_valid | output | 1 | Bus request valid |
| m_write | output | 1 | 1 write, 0 read |
| m_addr | output | 32 | Bus address |
| m_wdata | output | 32 | Bus write data |
| m_ready | input | 1 | Bus request accepted |
| m_rdata | input | 32 | Read data, valid with m_ready |
| res_flat | output | 48 | Four 12-bit results |
| err_sticky | output | 1 | Poll timeout seen |

## Verification
A wrong sequencer state shows on the bus port at the next request. A skipped or repeated write, a wrong address, or an extra poll appears in the transaction log the bench compares as soon as the round ends. A wrong point index or extraction error shows in the result word of that point when the round ends. A lost count or miscounted poll miss in the timeout logic shows as a missing or spurious `err_sticky` and as a stale or fresh result on the abandoned point.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_NEXT, SQ_MUX, SQ_PNP, SQ_EN, SQ_POLL, SQ_GAP, SQ_VOLT
  } sq_state_t;
endpackage

// File: rtl/tsense_tick.sv
module tsense_tick #(
  parameter int PRE = 256,
  parameter int CW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] unit_cnt,
  input  logic [CW-1:0] round_ivl,
  output logic          go
);
  localparam int PW = $clog2(PRE);

  logic [PW-1:0] pre_q, pre_d;
  logic [CW-1:0] unit_q, unit_d, ivl_q, ivl_d;
  logic          go_q, go_d;
  logic          pre_wrap, unit_hit, ivl_hit;

  always_comb begin
    pre_wrap = (pre_q == PW'(PRE - 1));
    unit_hit = pre_wrap &&
               (({1'b0, unit_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, unit_cnt});
    ivl_hit  = unit_hit &&
               (({1'b0, ivl_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, round_ivl});
    if (!run) begin
      pre_d  = '0;
      unit_d = '0;
      ivl_d  = '0;
      go_d   = 1'b0;
    end else begin
      pre_d  = pre_wrap ? '0 : pre_q + PW'(1);
      unit_d = unit_hit ? '0 : (pre_wrap ? unit_q + CW'(1) : unit_q);
      ivl_d  = ivl_hit  ? '0 : (unit_hit ? ivl_q + CW'(1) : ivl_q);
      go_d   = ivl_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
      ivl_q  <= '0;
      go_q   <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
      ivl_q  <= ivl_d;
      go_q   <= go_d;
    end
  end

  assign go = go_q;
endmodule

// File: rtl/tsense_pick.sv
module tsense_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  first
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign first = req & (~req + N'(1));
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
  import tsense_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NPT = 4,
  parameter int RW  = 12,
  parameter int TW  = 32,
  parameter int GW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [NPT-1:0]    pt_en,
  input  logic [1:0]        wr_ctl,
  input  logic [AW-1:0]     mux_addr,
  input  logic [DW-1:0]     mux_val,
  input  logic [AW-1:0]     pnp_addr,
  input  logic [NPT*DW-1:0] pnp_val,
  input  logic [AW-1:0]     en_addr,
  input  logic [DW-1:0]     en_val,
  input  logic [AW-1:0]     vld_addr,
  input  logic [AW-1:0]     volt_addr,
  input  logic              rd_sep,
  input  logic [$clog2(DW):0]   vld_mask,
  input  logic [$clog2(DW)-1:0] volt_shift,
  input  logic [GW-1:0]     poll_gap,
  input  logic [TW-1:0]     tmo_polls,
  output logic              m_valid,
  output logic              m_write,
  output logic [AW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ready,
  input  logic [DW-1:0]     m_rdata,
  output logic              st_en,
  output logic [$clog2(NPT)-1:0] st_idx,
  output logic [RW-1:0]     st_val,
  output logic              err
);
  localparam int PW = $clog2(DW);
  localparam int IW = $clog2(NPT);

  sq_state_t       st_q, st_d;
  logic [NPT-1:0]  rem_q, rem_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [TW-1:0]   miss_q, miss_d;
  logic [GW-1:0]   gap_q, gap_d;
  logic            err_q, err_d;

  logic [IW-1:0]   pk_idx;
  logic [NPT-1:0]  pk_first;
  logic [DW-1:0]   pnp_arr [NPT];
  logic            ack, hit, give_up;
  sq_state_t       wr_first;

  tsense_pick #(.N(NPT), .IW(IW)) u_pick (
    .req(rem_q), .idx(pk_idx), .first(pk_first)
  );

  for (genvar p = 0; p < NPT; p++) begin : g_pnp
    assign pnp_arr[p] = pnp_val[p*DW +: DW];
  end

  always_comb begin
    ack      = m_valid && m_ready;
    hit      = (m_rdata[vld_mask[PW-1:0]] == vld_mask[PW]);
    give_up  = !(&tmo_polls) && ((miss_q + TW'(1)) >= tmo_polls);
    st_val   = RW'(m_rdata >> volt_shift);
    st_idx   = idx_q;
    wr_first = wr_ctl[1] ? SQ_MUX : (wr_ctl[0] ? SQ_PNP : SQ_EN);

    m_valid = 1'b0;
    m_write = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    unique case (st_q)
      SQ_MUX:  begin m_valid = 1'b1; m_write = 1'b1; m_addr = mux_addr; m_wdata = mux_val; end
      SQ_PNP:  begin m_valid = 1'b1; m_write = 1'b1; m_addr = pnp_addr; m_wdata = pnp_arr[idx_q]; end
      SQ_EN:   begin m_valid = 1'b1; m_write = 1'b1; m_addr = en_addr;  m_wdata = en_val; end
      SQ_POLL: begin m_valid = 1'b1; m_addr = vld_addr; end
      SQ_VOLT: begin m_valid = 1'b1; m_addr = volt_addr; end
      default: ;
    endcase

    st_d   = st_q;
    rem_d  = rem_q;
    idx_d  = idx_q;
    miss_d = miss_q;
    gap_d  = gap_q;
    err_d  = err_q;
    st_en  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (go) begin
        rem_d = pt_en;
        st_d  = SQ_NEXT;
      end
      SQ_NEXT: if (rem_q == '0) begin
        st_d = SQ_IDLE;
      end else begin
        idx_d = pk_idx;
        rem_d = rem_q & ~pk_first;
        st_d  = wr_first;
      end
      SQ_MUX: if (ack) st_d = wr_ctl[0] ? SQ_PNP : SQ_EN;
      SQ_PNP: if (ack) st_d = SQ_EN;
      SQ_EN: if (ack) begin
        miss_d = '0;
        st_d   = SQ_POLL;
      end
      SQ_POLL: if (ack) begin
        if (hit) begin
          st_en = !rd_sep;
          st_d  = rd_sep ? SQ_VOLT : SQ_NEXT;
        end else if (give_up) begin
          err_d = 1'b1;
          st_d  = SQ_NEXT;
        end else begin
          miss_d = miss_q + TW'(1);
          gap_d  = '0;
          st_d   = (poll_gap == '0) ? SQ_POLL : SQ_GAP;
        end
      end
      SQ_GAP: begin
        gap_d = gap_q + GW'(1);
        if ((gap_q + GW'(1)) >= poll_gap) st_d = SQ_POLL;
      end
      SQ_VOLT: if (ack) begin
        st_en = 1'b1;
        st_d  = SQ_NEXT;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      rem_q  <= '0;
      idx_q  <= '0;
      miss_q <= '0;
      gap_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      idx_q  <= idx_d;
      miss_q <= miss_d;
      gap_q  <= gap_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/tsense_sequencer.sv
module tsense_sequencer #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NPT = 4,
  parameter int RW  = 12,
  parameter int CW  = 10,
  parameter int PRE = 256,
  parameter int TW  = 32,
  parameter int GW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CW-1:0]     unit_cnt,
  input  logic [CW-1:0]     round_ivl,
  input  logic [NPT-1:0]    pt_en,
  input  logic [1:0]        wr_ctl,
  input  logic [AW-1:0]     mux_addr,
  input  logic [DW-1:0]     mux_val,
  input  logic [AW-1:0]     pnp_addr,
  input  logic [NPT*DW-1:0] pnp_val,
  input  logic [AW-1:0]     en_addr,
  input  logic [DW-1:0]     en_val,
  input  logic [AW-1:0]     vld_addr,
  input  logic [AW-1:0]     volt_addr,
  input  logic              rd_sep,
  input  logic [$clog2(DW):0]   vld_mask,
  input  logic [$clog2(DW)-1:0] volt_shift,
  input  logic [GW-1:0]     poll_gap,
  input  logic [TW-1:0]     tmo_polls,
  output logic              m_valid,
  output logic              m_write,
  output logic [AW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ready,
  input  logic [DW-1:0]     m_rdata,
  output logic [NPT*RW-1:0] res_flat,
  output logic              err_sticky
);
  localparam int IW = $clog2(NPT);

  logic          go;
  logic          st_en;
  logic [IW-1:0] st_idx;
  logic [RW-1:0] st_val;

  tsense_tick #(.PRE(PRE), .CW(CW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run),
    .unit_cnt(unit_cnt), .round_ivl(round_ivl), .go(go)
  );

  tsense_seq #(.AW(AW), .DW(DW), .NPT(NPT), .RW(RW), .TW(TW), .GW(GW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .pt_en(pt_en), .wr_ctl(wr_ctl),
    .mux_addr(mux_addr), .mux_val(mux_val), .pnp_addr(pnp_addr),
    .pnp_val(pnp_val), .en_addr(en_addr), .en_val(en_val),
    .vld_addr(vld_addr), .volt_addr(volt_addr), .rd_sep(rd_sep),
    .vld_mask(vld_mask), .volt_shift(volt_shift), .poll_gap(poll_gap),
    .tmo_polls(tmo_polls), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
    .m_rdata(m_rdata), .st_en(st_en), .st_idx(st_idx), .st_val(st_val),
    .err(err_sticky)
  );

  for (genvar p = 0; p < NPT; p++) begin : g_res
    logic [RW-1:0] res_q;
    logic          res_we;
    assign res_we = st_en && (st_idx == IW'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (res_we) res_q <= st_val;
    end
    assign res_flat[p*RW +: RW] = res_q;
  end
endmodule

// File: rtl/tsense_sequencer_chk.sv
module tsense_sequencer_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NPT = 4,
  parameter int RW  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_write,
  input logic [AW-1:0]     m_addr,
  input logic [DW-1:0]     m_wdata,
  input logic              m_ready,
  input logic [NPT*RW-1:0] res_flat,
  input logic              err_sticky
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_write) &&
                               $stable(m_addr) && $stable(m_wdata)));

  a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_write) |-> (m_wdata == '0));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  a_r7_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> $past(m_valid && m_ready && !m_write));

  a_r6_result_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_flat) |-> $past(m_valid && m_ready && !m_write));
endmodule

bind tsense_sequencer tsense_sequencer_chk #(
  .AW(AW), .DW(DW), .NPT(NPT), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
  .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
  .res_flat(res_flat), .err_sticky(err_sticky)
);

// File: tb/sim_tsense_sequencer.sv
module sim_tsense_sequencer;
  localparam logic [31:0] A_MUX = 32'h0000_1000, A_PNP = 32'h0000_2000,
                          A_EN  = 32'h0000_3000, A_VLD = 32'h0000_4000,
                          A_VLT = 32'h0000_4004;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [9:0] unit_cnt = 10'd1, round_ivl = 10'd1;
  logic [3:0] pt_en = '0;
  logic [1:0] wr_ctl = 2'b11;
  logic [31:0] mux_val = 32'h800, en_val = 32'h800;
  logic [127:0] pnp_val = {32'd16, 32'd3, 32'd2, 32'd1};
  logic rd_sep = 1'b0;
  logic [5:0] vld_mask = 6'h20 | 6'd20;
  logic [4:0] volt_shift = '0;
  logic [7:0] poll_gap = '0;
  logic [31:0] tmo_polls = '1;
  logic m_valid, m_write, m_ready = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;
  logic [47:0] res_flat;
  logic err_sticky;

  tsense_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .unit_cnt(unit_cnt),
    .round_ivl(round_ivl), .pt_en(pt_en), .wr_ctl(wr_ctl),
    .mux_addr(A_MUX), .mux_val(mux_val), .pnp_addr(A_PNP), .pnp_val(pnp_val),
    .en_addr(A_EN), .en_val(en_val), .vld_addr(A_VLD),
    .volt_addr(rd_sep ? A_VLT : A_VLD), .rd_sep(rd_sep), .vld_mask(vld_mask),
    .volt_shift(volt_shift), .poll_gap(poll_gap), .tmo_polls(tmo_polls),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .res_flat(res_flat),
    .err_sticky(err_sticky)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // ADC model state and transaction log
  int miss_need [4];
  logic [11:0] volt_v [4];
  int conv_k = 0, poll_seen = 0;
  logic lg_w [64];
  logic [31:0] lg_a [64], lg_d [64];
  int lg_n = 0;
  logic e_w [64];
  logic [31:0] e_a [64], e_d [64];
  int e_n;
  logic [11:0] exp_res [4];
  bit exp_err = 1'b0;
  bit slow_ready = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      if (lg_n < 64) begin
        lg_w[lg_n] = m_write; lg_a[lg_n] = m_addr; lg_d[lg_n] = m_wdata;
      end
      lg_n++;
      if (m_write && m_addr == A_EN) begin conv_k++; poll_seen = 0; end
      if (!m_write && m_addr == A_VLD) poll_seen++;
    end
  end

  function automatic logic [31:0] vld_word(input bit hit, input int k);
    logic [31:0] w;
    w = rd_sep ? 32'h0 : (32'(volt_v[k]) << volt_shift);
    w[vld_mask[4:0]] = hit ? vld_mask[5] : ~vld_mask[5];
    return w;
  endfunction

  initial begin : slave
    forever begin
      @(negedge clk);
      m_ready = slow_ready ? ($urandom % 3 != 0) : 1'b1;
      if (m_valid && !m_write && conv_k > 0) begin
        if (m_addr == A_VLD)
          m_rdata = vld_word(poll_seen >= miss_need[conv_k-1], conv_k - 1);
        else
          m_rdata = 32'(volt_v[conv_k-1]) << volt_shift;
      end else begin
        m_rdata = $urandom;
      end
    end
  end

  task automatic add_e(input logic w, input logic [31:0] a, input logic [31:0] d);
    e_w[e_n] = w; e_a[e_n] = a; e_d[e_n] = d; e_n++;
  endtask

  // Runs one round and checks the log, results and error flag
  task automatic run_round(input string req);
    int k, lat, polls, tgt;
    bit ok, valid;
    e_n = 0; k = 0;
    for (int p = 0; p < 4; p++) begin
      if (pt_en[p]) begin
        if (wr_ctl[1]) add_e(1'b1, A_MUX, mux_val);
        if (wr_ctl[0]) add_e(1'b1, A_PNP, pnp_val[p*32 +: 32]);
        add_e(1'b1, A_EN, en_val);
        valid = (&tmo_polls) || (miss_need[k] < int'(tmo_polls));
        polls = valid ? miss_need[k] + 1 : int'(tmo_polls);
        for (int i = 0; i < polls; i++) add_e(1'b0, A_VLD, 32'h0);
        if (valid && rd_sep) add_e(1'b0, A_VLT, 32'h0);
        if (valid) exp_res[p] = volt_v[k];
        else exp_err = 1'b1;
        k++;
      end
    end
    conv_k = 0; poll_seen = 0; lg_n = 0;
    tgt = int'(unit_cnt) * 256 * int'(round_ivl);
    @(negedge clk); run = 1'b1; lat = 0;
    while (!m_valid && lat < 5000 && pt_en != 0) begin
      @(negedge clk); lat++;
    end
    if (pt_en == 0) repeat (tgt + 4) @(negedge clk);
    run = 1'b0;
    if (pt_en != 0)
      chk(lat >= tgt && lat <= tgt + 4, "R1", "round start latency", lat, tgt);
    repeat (900) @(negedge clk);
    chk(lg_n == e_n, req, "transaction count", lg_n, e_n);
    ok = 1'b1;
    for (int i = 0; i < e_n && i < lg_n; i++) begin
      if (ok && (lg_w[i] !== e_w[i] || lg_a[i] !== e_a[i] ||
                 (e_w[i] && lg_d[i] !== e_d[i]))) begin
        ok = 1'b0;
        chk(1'b0, req, $sformatf("transaction %0d addr", i), lg_a[i], e_a[i]);
      end
    end
    if (ok) chk(1'b1, req, "transaction order", 0, 0);
    for (int p = 0; p < 4; p++)
      chk(res_flat[p*12 +: 12] == exp_res[p], pt_en[p] ? "R6" : "R2",
          $sformatf("result point %0d", p), res_flat[p*12 +: 12], exp_res[p]);
    chk(err_sticky == exp_err, "R7", "sticky error", err_sticky, exp_err);
  endtask

  task automatic set_adc(input int m0, input int m1, input int m2, input int m3);
    miss_need[0] = m0; miss_need[1] = m1; miss_need[2] = m2; miss_need[3] = m3;
    for (int i = 0; i < 4; i++) volt_v[i] = 12'($urandom);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) exp_res[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(res_flat == '0, "R9", "reset results", res_flat, 0);
    chk(err_sticky == 1'b0, "R9", "reset error", err_sticky, 0);
    chk(m_valid == 1'b0, "R9", "reset request", m_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3: all points, both writes, longer period
    unit_cnt = 10'd1; round_ivl = 10'd2; pt_en = 4'hF; wr_ctl = 2'b11;
    set_adc(0, 0, 0, 0);
    run_round("R3");

    // R2 R4 R8: odd mask, active-low valid, shift, polling gap, slow ready
    round_ivl = 10'd1; pt_en = 4'b0101; wr_ctl = 2'b01;
    vld_mask = 6'd25; volt_shift = 5'd4; poll_gap = 8'd3; tmo_polls = 32'd10;
    set_adc(2, 3, 0, 0);
    run_round("R4");

    // R5: separate voltage read, only mux write
    pt_en = 4'b1010; wr_ctl = 2'b10; rd_sep = 1'b1; vld_mask = 6'h20 | 6'd31;
    volt_shift = 5'd7; poll_gap = 8'd0;
    set_adc(1, 0, 0, 0);
    run_round("R5");

    // R7: timeout on second visited point keeps its old result
    pt_en = 4'b0011; wr_ctl = 2'b11; rd_sep = 1'b0; tmo_polls = 32'd3;
    set_adc(0, 5, 0, 0);
    run_round("R7");

    // R7: all-ones timeout never gives up
    tmo_polls = '1; pt_en = 4'b0100;
    set_adc(6, 0, 0, 0);
    run_round("R7");

    // R2: empty mask, no traffic
    pt_en = 4'b0000;
    run_round("R2");

    // Random configurations
    for (int r = 0; r < 8; r++) begin
      pt_en = 4'($urandom); wr_ctl = 2'($urandom); rd_sep = 1'($urandom);
      vld_mask = {1'($urandom), 5'(20 + $urandom % 12)};
      volt_shift = 5'($urandom % 8); poll_gap = 8'($urandom % 4);
      tmo_polls = ($urandom % 3 == 0) ? '1 : 32'(2 + $urandom % 4);
      slow_ready = 1'($urandom);
      set_adc($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5);
      run_round("R3");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule